// File: doc/BRIEF.md
# Display List Fetch Engine

This block builds the memory traffic for one visible scanline of a display processor that is driven by lists in memory. A root list is held in memory as three-byte zone entries. Each zone entry names a per-zone object list, a row offset, an address-gap ("holey") mode and an interrupt flag. Each object in a zone list is described by a four-byte or five-byte header. The header gives a graphics base address, a palette, an inverted width and a horizontal position. The extended form also carries a write-mode bit and an indirect (character) bit.

For every graphics byte it needs, the engine issues a read on a simple request/acknowledge port. It passes the byte to a pixel writer together with the object's position, palette, mode bits and the byte's ordinal. Bytes that fall in a gap region are not read; they are handed on marked as transparent. The engine also tallies the CPU cycles its DMA steals, reports the total with a done strobe at the end of the line, and pulses a non-maskable interrupt when a newly fetched zone entry asks for one.

The controller is one state machine. Its states are:
- IDLE waits for `line_start`.
- ZONE reads the three bytes of a zone entry.
- PROBE reads the second byte of the next object header.
- HDR reads the remaining header bytes.
- PTR reads a character pointer in indirect mode.
- GFX reads a graphics byte, or skips a gap byte.
- DONE strobes the result.

Its transitions are:
- IDLE goes to DONE when DMA is off, to ZONE on the first visible line, and to PROBE otherwise.
- ZONE goes to PROBE after a start-of-frame fetch, or to DONE after an end-of-zone fetch.
- PROBE goes to HDR when an object is present. When the list has ended, it goes to ZONE if the offset was zero, and to DONE otherwise.
- HDR goes to PROBE (read mode 1), PTR (indirect) or GFX (direct).
- PTR goes to GFX.
- GFX stays in GFX, or goes back to PTR for the next character, or to PROBE after the object's last byte.
- DONE goes to IDLE.

Top module: `dl_fetch_engine`

## Requirements
- R1: A `line_start` with `first_line` and `dma_en` both high loads the root pointer from `list_root`. The engine then reads the zone entry at root, root+1 and root+2 and advances the root pointer by 3. Byte 0 of the entry carries the interrupt flag in bit 7, the gap mode in bits 6:5 and the row offset in bits 3:0. Byte 1 is the list address high byte and byte 2 is the low byte.
- R2: Each object begins with a read of list+1. A value v with (v AND 0x5F) = 0 ends the list. Otherwise, v[4:0] = 0 selects the five-byte header and any other value selects the four-byte header. The remaining header bytes are then read at list+0, list+2, list+3 and, for the five-byte form only, list+4. The list pointer then advances by 5 or 4.
- R3: The four-byte header holds, by offset: 0 = address low, 1 = palette/width, 2 = address high, 3 = horizontal position. The five-byte header holds: 0 = address low, 1 = mode (bit 7 = write mode, bit 5 = indirect), 2 = address high, 3 = palette/width, 4 = horizontal position. The palette is palette/width[7:5]. The width in bytes is (NOT palette/width[4:0]) + 1, giving 1 to 32. A four-byte header clears the indirect bit and leaves the write-mode bit at its last value, which is 0 after reset.
- R4: In direct mode the data address starts at base + (row offset × 256) and increments by one for each byte, wrapping at 16 bits.
- R5: In indirect mode, character i is handled in two steps. First a pointer byte is read at base + i. The data address is then {char_base + row offset, pointer}, with the high byte wrapping at 8 bits. When `char_wide` is high and `read_mode` is not 3, two consecutive bytes are fetched per character.
- R6: With gap mode 2, a data address with (a AND 0x9000) = 0x9000 is not read. With gap mode 1, an address with (a AND 0x8800) = 0x8800 is not read. Such a byte is passed on with `pix_skip` high and data 0, and the address still advances.
- R7: At the end of each line's list, the row offset decrements if it is non-zero. If it was zero, the next zone entry is read, and `dli_nmi` pulses for one cycle when that entry's bit 7 is set.
- R8: The count reported on `dma_cycles` is the sum of these terms:
  - 5 for every enabled line, plus 15 more on the first line;
  - 8 per four-byte header and 10 per five-byte header;
  - per graphics byte unless read mode is 1: width × 3 in direct mode, width × 6 in indirect mode, or width × 9 in indirect mode with `char_wide`;
  - 4 at the end of the line, or 10 when a new zone entry is fetched;
  - 1 per interrupt raised.
- R9: With `read_mode` = 1 the headers are read, but no pointer or graphics reads take place and no pixel events are produced.
- R10: A `line_start` with `dma_en` low makes no reads and strobes `line_done` on the next cycle with `dma_cycles` = 0.
- R11: Once `mem_req` is raised, it and `mem_addr` hold steady until a cycle with `mem_ack` high completes the read, and `mem_rdata` is taken in that cycle.
- R12: Each pixel event carries the object's horizontal position, palette, write-mode and indirect bits, and a byte ordinal that starts at 0 for each object.
- R13: After reset the engine is idle: no request, no pixel event, no interrupt and no done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle pulse that starts a line while idle |
| first_line | input | 1 | Marks the line as the first visible one |
| dma_en | input | 1 | DMA enable for this line |
| list_root | input | 16 | Root zone-list address |
| char_base | input | 8 | Character base high byte |
| read_mode | input | 2 | Read mode (1 = no graphics, 3 = single-byte characters) |
| char_wide | input | 1 | Two-byte characters in indirect mode |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_ack | input | 1 | Read completes this cycle |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| pix_valid | output | 1 | Pixel byte event |
| pix_skip | output | 1 | Event is a skipped gap byte |
| pix_data | output | 8 | Graphics byte |
| pix_hpos | output | 8 | Object horizontal position |
| pix_palette | output | 3 | Object palette |
| pix_wmode | output | 1 | Write-mode bit |
| pix_indirect | output | 1 | Indirect-mode bit |
| pix_seq | output | 7 | Byte ordinal within the object |
| dli_nmi | output | 1 | Interrupt pulse |
| line_done | output | 1 | End-of-line strobe |
| dma_cycles | output | 16 | Stolen-cycle total, valid with `line_done` |

## Verification
The bench attacks the following corner cases, each named with the failure it would expose:
- Header byte order is a target. A design that swapped the palette/width and high-address slots of the four-byte form would fetch from wrong addresses. A design that reset the write-mode bit on a four-byte header would mislabel later events.
- A five-byte header whose width field is zero is a target. It stands for 32 bytes, and an engine that forgot the inversion would stop after one byte.
- Gap regions under both gap modes are a target. An engine that read them would show extra memory traffic, and one that dropped them would lose the transparent events the pixel writer needs.
- Zone changes, interrupt flags, read mode 1, two-byte characters and disabled lines are targets. A wrong offset test, a missed interrupt or a miscounted cost term shows up as a wrong read sequence or a wrong cycle total.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ZONE,
        S_PROBE,
        S_HDR,
        S_PTR,
        S_GFX,
        S_DONE
    } dlf_state_t;

    // stolen-cycle cost terms
    localparam int unsigned C_STARTUP       = 5;
    localparam int unsigned C_FIRST_EXTRA   = 15;
    localparam int unsigned C_HDR_SHORT     = 8;
    localparam int unsigned C_HDR_LONG      = 10;
    localparam int unsigned C_BYTE_DIRECT   = 3;
    localparam int unsigned C_BYTE_IND      = 6;
    localparam int unsigned C_BYTE_IND_WIDE = 9;
    localparam int unsigned C_SHUT_LINE     = 4;
    localparam int unsigned C_SHUT_ZONE     = 10;
    localparam int unsigned C_INT_TICK      = 1;

    localparam logic [7:0]  END_MASK   = 8'h5F;
    localparam logic [15:0] GAP_MASK_W = 16'h9000;
    localparam logic [15:0] GAP_MASK_N = 16'h8800;
    localparam logic [1:0]  RM_NO_GFX  = 2'd1;
    localparam logic [1:0]  RM_NARROW  = 2'd3;

endpackage

// File: rtl/dlf_addr_gen.sv
module dlf_addr_gen (
    input  logic [15:0] gfx_base,
    input  logic [3:0]  row_off,
    input  logic [7:0]  char_base,
    input  logic [7:0]  ptr_byte,
    input  logic [15:0] cur_addr,
    input  logic [1:0]  gap_mode,
    output logic [15:0] direct_start,
    output logic [15:0] char_start,
    output logic        gap_hit
);
    import dlf_pkg::*;

    always_comb begin
        direct_start = gfx_base + {4'h0, row_off, 8'h00};
        char_start   = {char_base + {4'h0, row_off}, ptr_byte};
        unique case (gap_mode)
            2'd2:    gap_hit = (cur_addr & GAP_MASK_W) == GAP_MASK_W;
            2'd1:    gap_hit = (cur_addr & GAP_MASK_N) == GAP_MASK_N;
            default: gap_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dlf_cycle_acc.sv
module dlf_cycle_acc #(
    parameter int CYC_W = 16,
    parameter int ADD_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [ADD_W-1:0] add_val,
    output logic [CYC_W-1:0] total
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      total <= '0;
        else if (clr)    total <= CYC_W'(add_val);
        else if (add_en) total <= total + CYC_W'(add_val);
    end
endmodule

// File: rtl/dl_fetch_engine.sv
module dl_fetch_engine #(
    parameter int CYC_W = 16,
    parameter int ADD_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             first_line,
    input  logic             dma_en,
    input  logic [15:0]      list_root,
    input  logic [7:0]       char_base,
    input  logic [1:0]       read_mode,
    input  logic             char_wide,
    output logic             mem_req,
    output logic [15:0]      mem_addr,
    input  logic             mem_ack,
    input  logic [7:0]       mem_rdata,
    output logic             pix_valid,
    output logic             pix_skip,
    output logic [7:0]       pix_data,
    output logic [7:0]       pix_hpos,
    output logic [2:0]       pix_palette,
    output logic             pix_wmode,
    output logic             pix_indirect,
    output logic [6:0]       pix_seq,
    output logic             dli_nmi,
    output logic             line_done,
    output logic [CYC_W-1:0] dma_cycles
);
    import dlf_pkg::*;

    localparam int WID_W = 6;

    dlf_state_t state, state_nx;

    logic [15:0] root_ptr, dl_base, dl_walk, data_addr;
    logic [1:0]  zone_idx, hdr_idx, gap_mode;
    logic        zone_at_end, zone_int;
    logic [7:0]  zone_hi, gfx_lo, gfx_hi, hpos_r, pw_r;
    logic [3:0]  row_off;
    logic        is_ext, is_ind, wmode;
    logic [WID_W-1:0] obj_i;
    logic        sub;
    logic [6:0]  seq;

    logic [15:0] direct_start, char_start;
    logic        gap_hit;

    logic xfer, probe_end, hdr_last, wide, sub_last, last_byte, gfx_step;
    logic [WID_W-1:0] width;
    logic [ADD_W-1:0] per_byte, gfx_cost, hdr_cost, add_val;
    logic acc_clr, acc_add;
    logic [CYC_W-1:0] total;

    dlf_addr_gen u_addr (
        .gfx_base    ({gfx_hi, gfx_lo}),
        .row_off     (row_off),
        .char_base   (char_base),
        .ptr_byte    (mem_rdata),
        .cur_addr    (data_addr),
        .gap_mode    (gap_mode),
        .direct_start(direct_start),
        .char_start  (char_start),
        .gap_hit     (gap_hit)
    );

    dlf_cycle_acc #(.CYC_W(CYC_W), .ADD_W(ADD_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_clr),
        .add_en (acc_add),
        .add_val(add_val),
        .total  (total)
    );

    // shared decode
    always_comb begin
        xfer      = mem_req && mem_ack;
        probe_end = (mem_rdata & END_MASK) == 8'h00;
        hdr_last  = is_ext ? (hdr_idx == 2'd3) : (hdr_idx == 2'd2);
        width     = {1'b0, ~pw_r[4:0]} + WID_W'(1);
        wide      = is_ind && char_wide && (read_mode != RM_NARROW);
        sub_last  = !wide || sub;
        last_byte = obj_i == width - WID_W'(1);
        gfx_step  = (state == S_GFX) && (gap_hit || mem_ack);
        per_byte  = is_ind ? (char_wide ? ADD_W'(C_BYTE_IND_WIDE) : ADD_W'(C_BYTE_IND))
                           : ADD_W'(C_BYTE_DIRECT);
        gfx_cost  = ADD_W'(width) * per_byte;
        hdr_cost  = is_ext ? ADD_W'(C_HDR_LONG) : ADD_W'(C_HDR_SHORT);
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (line_start)
                         state_nx = !dma_en ? S_DONE : (first_line ? S_ZONE : S_PROBE);
            S_ZONE:  if (xfer && zone_idx == 2'd2)
                         state_nx = zone_at_end ? S_DONE : S_PROBE;
            S_PROBE: if (xfer)
                         state_nx = !probe_end ? S_HDR : ((row_off == 4'd0) ? S_ZONE : S_DONE);
            S_HDR:   if (xfer && hdr_last)
                         state_nx = (read_mode == RM_NO_GFX) ? S_PROBE : (is_ind ? S_PTR : S_GFX);
            S_PTR:   if (xfer) state_nx = S_GFX;
            S_GFX:   if (gfx_step && sub_last)
                         state_nx = last_byte ? S_PROBE : (is_ind ? S_PTR : S_GFX);
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            root_ptr <= '0; dl_base <= '0; dl_walk <= '0; data_addr <= '0;
            zone_idx <= '0; hdr_idx <= '0; gap_mode <= '0;
            zone_at_end <= 1'b0; zone_int <= 1'b0;
            zone_hi <= '0; gfx_lo <= '0; gfx_hi <= '0; hpos_r <= '0; pw_r <= '0;
            row_off <= '0; is_ext <= 1'b0; is_ind <= 1'b0; wmode <= 1'b0;
            obj_i <= '0; sub <= 1'b0; seq <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (line_start && dma_en) begin
                    if (first_line) begin
                        root_ptr    <= list_root;
                        zone_idx    <= 2'd0;
                        zone_at_end <= 1'b0;
                    end else begin
                        dl_walk <= dl_base;
                    end
                end
                S_ZONE: if (xfer) begin
                    unique case (zone_idx)
                        2'd0: begin
                            zone_int <= mem_rdata[7];
                            gap_mode <= mem_rdata[6:5];
                            row_off  <= mem_rdata[3:0];
                        end
                        2'd1: zone_hi <= mem_rdata;
                        default: begin
                            dl_base  <= {zone_hi, mem_rdata};
                            dl_walk  <= {zone_hi, mem_rdata};
                            root_ptr <= root_ptr + 16'd3;
                        end
                    endcase
                    zone_idx <= (zone_idx == 2'd2) ? 2'd0 : zone_idx + 2'd1;
                end
                S_PROBE: if (xfer) begin
                    if (probe_end) begin
                        if (row_off == 4'd0) begin
                            zone_at_end <= 1'b1;
                            zone_idx    <= 2'd0;
                        end else begin
                            row_off <= row_off - 4'd1;
                        end
                    end else begin
                        is_ext  <= mem_rdata[4:0] == 5'd0;
                        is_ind  <= (mem_rdata[4:0] == 5'd0) && mem_rdata[5];
                        if (mem_rdata[4:0] == 5'd0) wmode <= mem_rdata[7];
                        else                        pw_r  <= mem_rdata;
                        hdr_idx <= 2'd0;
                    end
                end
                S_HDR: if (xfer) begin
                    unique case (hdr_idx)
                        2'd0: gfx_lo <= mem_rdata;
                        2'd1: gfx_hi <= mem_rdata;
                        2'd2: if (is_ext) pw_r <= mem_rdata; else hpos_r <= mem_rdata;
                        default: hpos_r <= mem_rdata;
                    endcase
                    hdr_idx <= hdr_idx + 2'd1;
                    if (hdr_last) begin
                        dl_walk   <= dl_walk + (is_ext ? 16'd5 : 16'd4);
                        obj_i     <= '0;
                        sub       <= 1'b0;
                        seq       <= '0;
                        data_addr <= direct_start;
                    end
                end
                S_PTR: if (xfer) begin
                    data_addr <= char_start;
                    sub       <= 1'b0;
                end
                S_GFX: if (gfx_step) begin
                    data_addr <= data_addr + 16'd1;
                    seq       <= seq + 7'd1;
                    if (sub_last) begin
                        sub <= 1'b0;
                        if (!last_byte) obj_i <= obj_i + WID_W'(1);
                    end else begin
                        sub <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs and cost events
    always_comb begin
        mem_req      = 1'b0;
        mem_addr     = '0;
        pix_valid    = 1'b0;
        pix_skip     = 1'b0;
        pix_data     = '0;
        pix_hpos     = hpos_r;
        pix_palette  = pw_r[7:5];
        pix_wmode    = wmode;
        pix_indirect = is_ind;
        pix_seq      = seq;
        dli_nmi      = 1'b0;
        line_done    = 1'b0;
        dma_cycles   = '0;
        acc_clr      = 1'b0;
        acc_add      = 1'b0;
        add_val      = '0;
        unique case (state)
            S_IDLE: begin
                acc_clr = line_start;
                add_val = !dma_en ? '0 :
                          (first_line ? ADD_W'(C_STARTUP + C_FIRST_EXTRA) : ADD_W'(C_STARTUP));
            end
            S_ZONE: begin
                mem_req  = 1'b1;
                mem_addr = root_ptr + {14'd0, zone_idx};
                dli_nmi  = mem_ack && (zone_idx == 2'd2) && zone_int;
                acc_add  = dli_nmi;
                add_val  = ADD_W'(C_INT_TICK);
            end
            S_PROBE: begin
                mem_req  = 1'b1;
                mem_addr = dl_walk + 16'd1;
                acc_add  = mem_ack && probe_end;
                add_val  = (row_off == 4'd0) ? ADD_W'(C_SHUT_ZONE) : ADD_W'(C_SHUT_LINE);
            end
            S_HDR: begin
                mem_req  = 1'b1;
                mem_addr = dl_walk + ((hdr_idx == 2'd0) ? 16'd0 : {14'd0, hdr_idx} + 16'd1);
                acc_add  = mem_ack && hdr_last;
                add_val  = hdr_cost + ((read_mode == RM_NO_GFX) ? '0 : gfx_cost);
            end
            S_PTR: begin
                mem_req  = 1'b1;
                mem_addr = {gfx_hi, gfx_lo} + {10'd0, obj_i};
            end
            S_GFX: begin
                mem_req   = !gap_hit;
                mem_addr  = data_addr;
                pix_valid = gap_hit || mem_ack;
                pix_skip  = gap_hit;
                pix_data  = gap_hit ? 8'h00 : mem_rdata;
            end
            S_DONE: begin
                line_done  = 1'b1;
                dma_cycles = total;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dlf_chk.sv
module dlf_chk
    import dlf_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input dlf_state_t       st,
    input logic             line_start,
    input logic             dma_en,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [15:0]      mem_addr,
    input logic             pix_valid,
    input logic             pix_skip,
    input logic             dli_nmi,
    input logic             line_done,
    input logic [CYC_W-1:0] dma_cycles
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R6
    gap_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_skip |-> pix_valid && !mem_req);

    // R11
    data_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_skip |-> mem_req && mem_ack);

    // R10
    disabled_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) && line_start && !dma_en |=> line_done && (dma_cycles == '0) && !mem_req);

    // R7
    nmi_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dli_nmi |-> mem_req && mem_ack && !pix_valid);

    // R13
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> !mem_req && !pix_valid && !dli_nmi);

    // R13
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);
endmodule

bind dl_fetch_engine dlf_chk #(.CYC_W(CYC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (state),
    .line_start(line_start),
    .dma_en    (dma_en),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .pix_valid (pix_valid),
    .pix_skip  (pix_skip),
    .dli_nmi   (dli_nmi),
    .line_done (line_done),
    .dma_cycles(dma_cycles)
);

// File: tb/dl_fetch_engine_tb.sv
module dl_fetch_engine_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0, first_line = 1'b0, dma_en = 1'b0;
    logic [15:0] list_root = '0;
    logic [7:0]  char_base = '0;
    logic [1:0]  read_mode = '0;
    logic        char_wide = 1'b0;
    logic        mem_req, mem_ack = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        pix_valid, pix_skip, pix_wmode, pix_indirect, dli_nmi, line_done;
    logic [7:0]  pix_data, pix_hpos;
    logic [2:0]  pix_palette;
    logic [6:0]  pix_seq;
    logic [15:0] dma_cycles;

    always #5 clk = ~clk;

    logic [7:0] mem [0:4095];
    assign mem_rdata = mem[mem_addr[11:0]];

    dl_fetch_engine u_dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .first_line(first_line),
        .dma_en(dma_en), .list_root(list_root), .char_base(char_base),
        .read_mode(read_mode), .char_wide(char_wide), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .pix_valid(pix_valid), .pix_skip(pix_skip), .pix_data(pix_data),
        .pix_hpos(pix_hpos), .pix_palette(pix_palette), .pix_wmode(pix_wmode),
        .pix_indirect(pix_indirect), .pix_seq(pix_seq), .dli_nmi(dli_nmi),
        .line_done(line_done), .dma_cycles(dma_cycles)
    );

    int checks = 0, failures = 0;

    // expected and observed traces
    logic [28:0] exp_ev [0:1023];
    logic [28:0] got_ev [0:1023];
    logic [15:0] exp_rd [0:1023];
    logic [15:0] got_rd [0:1023];
    int exp_np, exp_nr, exp_nmi, got_np, got_nr, got_nmi, hs_err;
    int unsigned exp_cyc;
    logic [15:0] got_cyc;
    bit got_done;

    // reference state
    logic [15:0] r_dll, r_dl;
    logic [3:0]  r_off;
    logic [1:0]  r_gap;
    logic        r_wm = 1'b0;

    function automatic logic [28:0] pk(input logic sk, input logic wm, input logic ind,
        input logic [2:0] pal, input logic [6:0] sq, input logic [7:0] hp, input logic [7:0] d);
        return {sk, wm, ind, pal, sq, hp, d};
    endfunction

    function automatic logic [7:0] rd(input logic [15:0] a);
        if (exp_nr < 1024) exp_rd[exp_nr] = a;
        exp_nr++;
        return mem[a[11:0]];
    endfunction

    function automatic bit gap(input logic [1:0] m, input logic [15:0] a);
        return (m == 2'd2 && (a & 16'h9000) == 16'h9000) ||
               (m == 2'd1 && (a & 16'h8800) == 16'h8800);
    endfunction

    function automatic void ref_zone();
        logic [7:0] f, h, l;
        f = rd(r_dll); h = rd(r_dll + 16'd1); l = rd(r_dll + 16'd2);
        r_dll = r_dll + 16'd3;
        r_gap = f[6:5]; r_off = f[3:0]; r_dl = {h, l};
        if (f[7]) begin exp_nmi++; exp_cyc += 1; end
    endfunction

    function automatic void ref_line(input bit first, input bit en);
        logic [15:0] p, base, da;
        logic [7:0] m, lo, hi, pw, hp, ptr;
        logic [5:0] w;
        logic ind;
        logic [6:0] sq;
        int nb;
        exp_np = 0; exp_nr = 0; exp_cyc = 0; exp_nmi = 0;
        if (!en) return;
        if (first) begin exp_cyc += 15; r_dll = list_root; ref_zone(); end
        exp_cyc += 5;
        p = r_dl;
        forever begin
            m = rd(p + 16'd1);
            if ((m & 8'h5F) == 8'h00) break;
            if (m[4:0] == 5'd0) begin
                lo = rd(p); hi = rd(p + 16'd2); pw = rd(p + 16'd3); hp = rd(p + 16'd4);
                r_wm = m[7]; ind = m[5]; p = p + 16'd5; exp_cyc += 10;
            end else begin
                lo = rd(p); hi = rd(p + 16'd2); hp = rd(p + 16'd3);
                pw = m; ind = 1'b0; p = p + 16'd4; exp_cyc += 8;
            end
            w = {1'b0, ~pw[4:0]} + 6'd1;
            if (read_mode != 2'd1) begin
                exp_cyc += w * (ind ? (char_wide ? 9 : 6) : 3);
                nb = (ind && char_wide && read_mode != 2'd3) ? 2 : 1;
                base = {hi, lo};
                da = base + {4'h0, r_off, 8'h00};
                sq = '0;
                for (int i = 0; i < int'(w); i++) begin
                    if (ind) begin
                        ptr = rd(base + 16'(i));
                        da = {char_base + {4'h0, r_off}, ptr};
                    end
                    for (int j = 0; j < nb; j++) begin
                        if (exp_np < 1024) begin
                            if (gap(r_gap, da)) exp_ev[exp_np] = pk(1'b1, r_wm, ind, pw[7:5], sq, hp, 8'h00);
                            else                exp_ev[exp_np] = pk(1'b0, r_wm, ind, pw[7:5], sq, hp, rd(da));
                        end
                        exp_np++;
                        da = da + 16'd1; sq = sq + 7'd1;
                    end
                end
            end
        end
        if (r_off == 4'd0) begin exp_cyc += 10; ref_zone(); end
        else begin r_off = r_off - 4'd1; exp_cyc += 4; end
    endfunction

    // memory acknowledge driver
    initial forever begin
        @(negedge clk);
        mem_ack = ($urandom % 4) != 0;
    end

    // monitor
    logic p_req = 1'b0, p_ack = 1'b0;
    logic [15:0] p_addr = '0;
    initial forever begin
        @(negedge clk);
        #3;
        if (rst_n) begin
            if (p_req && !p_ack && (!mem_req || mem_addr != p_addr)) hs_err++;
            if (pix_valid) begin
                if (got_np < 1024)
                    got_ev[got_np] = {pix_skip, pix_wmode, pix_indirect, pix_palette, pix_seq, pix_hpos, pix_data};
                got_np++;
            end
            if (mem_req && mem_ack) begin
                if (got_nr < 1024) got_rd[got_nr] = mem_addr;
                got_nr++;
            end
            if (dli_nmi) got_nmi++;
            if (line_done) begin got_done = 1'b1; got_cyc = dma_cycles; end
        end
        p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic run_line(input bit first, input bit en);
        int first_bad;
        ref_line(first, en);
        got_np = 0; got_nr = 0; got_nmi = 0; got_done = 1'b0;
        @(negedge clk);
        line_start = 1'b1; first_line = first; dma_en = en;
        @(negedge clk);
        line_start = 1'b0;
        for (int t = 0; t < 6000 && !got_done; t++) @(negedge clk);
        check(got_done, "R8", "line_done strobe", got_done, 1);
        if (!en) begin
            check(got_cyc == 16'd0 && got_nr == 0, "R10", "disabled line cycles/reads",
                  got_cyc, 0);
        end else begin
            check(got_cyc == 16'(exp_cyc), "R8", "dma_cycles", got_cyc, exp_cyc);
        end
        first_bad = -1;
        for (int i = 0; i < exp_nr && i < got_nr && i < 1024; i++)
            if (first_bad < 0 && got_rd[i] != exp_rd[i]) first_bad = i;
        check(got_nr == exp_nr && first_bad < 0, "R1 R2 R4 R5", "read address trace",
              (first_bad < 0) ? got_nr : got_rd[first_bad],
              (first_bad < 0) ? exp_nr : exp_rd[first_bad]);
        first_bad = -1;
        for (int i = 0; i < exp_np && i < got_np && i < 1024; i++)
            if (first_bad < 0 && got_ev[i] != exp_ev[i]) first_bad = i;
        if (read_mode == 2'd1 && en)
            check(got_np == 0, "R9", "no pixel events in read mode 1", got_np, 0);
        else
            check(got_np == exp_np && first_bad < 0, "R3 R6 R12", "pixel event trace",
                  (first_bad < 0) ? got_np : got_ev[first_bad],
                  (first_bad < 0) ? exp_np : exp_ev[first_bad]);
        check(got_nmi == exp_nmi, "R7", "interrupt pulses", got_nmi, exp_nmi);
        @(negedge clk);
    endtask

    // lay out a random frame: 9 zone entries, up to 3 objects per zone list
    task automatic build_frame(input logic [15:0] root);
        logic [7:0] his [0:5];
        logic [15:0] dl;
        int nobj;
        his[0] = 8'h90; his[1] = 8'h88; his[2] = 8'h98;
        his[3] = 8'h40; his[4] = 8'h71; his[5] = 8'hF8;
        for (int a = 0; a < 4096; a++) mem[a] = 8'($urandom);
        for (int z = 0; z < 9; z++) begin
            dl = 16'hA200 + 16'(z * 64);
            mem[root[11:0] + 12'(3 * z)]     = {1'($urandom), 2'($urandom), 1'b0, 4'($urandom % 3)};
            mem[root[11:0] + 12'(3 * z + 1)] = dl[15:8];
            mem[root[11:0] + 12'(3 * z + 2)] = dl[7:0];
            nobj = $urandom % 4;
            for (int o = 0; o < nobj; o++) begin
                logic [7:0] pw;
                pw[7:5] = 3'($urandom);
                if ($urandom % 2 == 1) begin
                    pw[4:0] = ($urandom % 5 == 0) ? 5'd0 : 5'(28 + $urandom % 4);
                    mem[dl[11:0]]       = 8'($urandom);
                    mem[dl[11:0] + 12'd1] = {1'($urandom), 1'b1, 1'($urandom), 5'd0};
                    mem[dl[11:0] + 12'd2] = his[$urandom % 6];
                    mem[dl[11:0] + 12'd3] = pw;
                    mem[dl[11:0] + 12'd4] = 8'($urandom);
                    dl = dl + 16'd5;
                end else begin
                    pw[4:0] = ($urandom % 4 == 0) ? 5'd20 : 5'(28 + $urandom % 4);
                    mem[dl[11:0]]       = 8'($urandom);
                    mem[dl[11:0] + 12'd1] = pw;
                    mem[dl[11:0] + 12'd2] = his[$urandom % 6];
                    mem[dl[11:0] + 12'd3] = 8'($urandom);
                    dl = dl + 16'd4;
                end
            end
            mem[dl[11:0] + 12'd1] = ($urandom % 2 == 1) ? 8'h00 : 8'hA0;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4817));
        hs_err = 0;
        repeat (3) @(negedge clk);
        // R13 reset state
        check(!mem_req && !pix_valid && !dli_nmi && !line_done, "R13", "reset quiet",
              {mem_req, pix_valid, dli_nmi, line_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req && !line_done, "R13", "idle after reset", {mem_req, line_done}, 0);

        // directed: disabled line before any frame (R10)
        run_line(1'b0, 1'b0);

        for (int fr = 0; fr < 14; fr++) begin
            logic [15:0] root;
            root = {4'($urandom), 12'h100};
            list_root = root;
            char_base = 8'($urandom);
            char_wide = (fr % 3) == 1;
            // directed modes on early frames, random later
            if (fr == 0)      read_mode = 2'd0;
            else if (fr == 1) read_mode = 2'd1;
            else if (fr == 2) read_mode = 2'd3;
            else              read_mode = 2'($urandom);
            build_frame(root);
            run_line(1'b1, 1'b1);
            for (int ln = 1; ln < 7; ln++)
                run_line(1'b0, ($urandom % 8) != 0);
        end

        // R11 request held until acknowledged
        check(hs_err == 0, "R11", "request/address stability", hs_err, 0);
        finish_run();
    end
endmodule